// File: doc/BRIEF.md
# Delay-Line Calibration Sequencer

This block sequences the calibration of a high-resolution delay line. Software starts a single calibration by writing a one-cycle pulse to the calibrate bit. The sequencer then raises a request towards the delay line and holds it until the delay line reports lock. On the first lock the block sets a sticky ready flag, and raises an end-of-calibration interrupt if that interrupt is enabled.

When the periodic-enable input is high and the first calibration has completed, the sequencer recalibrates on its own. The wait between recalibrations is set by a 2-bit rate code. A recalibration leaves the ready flag set, so the timing counters it protects keep running.

A counter-start request is passed on only while the ready flag is set. This prevents the counters from starting on an uncalibrated delay line.

Top module: `dlcal_seq`

## Requirements
- R1: A one-cycle pulse on `cal_start_i` sets `cal_busy_o` at the next clock edge. At the following edge the sequencer is idle, so the request is accepted: `cal_req_o` goes to 1 and `cal_busy_o` clears.
- R2: `cal_req_o` stays at 1 until `lock_i` is sampled high, and falls at that edge. `ready_o` sets at the same edge and stays at 1 until reset.
- R3: `irq_o` sets at the edge where `ready_o` goes from 0 to 1, if `irq_en_i` is 1 at that edge. If `irq_en_i` is 0 at that edge, `irq_o` stays at 0.
- R4: `cnt_run_o` is `run_req_i AND ready_o`, registered one cycle. A start request made before the ready flag sets is blocked.
- R5: When `per_en_i` is 1 and `ready_o` is 1, each calibration is followed by exactly N clock cycles with `cal_req_o` at 0, and then a new calibration starts.
- R6: N is 2^(BASE_LOG2 + 2*code), where code is `rate_i`. With the default BASE_LOG2 = 14, codes 0, 1, 2 and 3 give 2^14, 2^16, 2^18 and 2^20 cycles.
- R7: A periodic recalibration does not clear `ready_o`, does not set `irq_o`, and does not stop `cnt_run_o`.
- R8: Once set, `irq_o` stays at 1 until a cycle with `irq_clr_i` at 1. It then reads 0 from the next edge on. A new set in the same cycle takes priority over the clear.
- R9: `per_en_i` has no effect before the first calibration completes: no calibration starts on its own.
- R10: `lock_i` is ignored while no calibration is in progress. It cannot set `ready_o`.
- R11: After a synchronous reset, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start_i | input | 1 | Write-one pulse to the calibrate bit |
| per_en_i | input | 1 | Enables periodic recalibration |
| rate_i | input | 2 | Code selecting the recalibration interval |
| irq_en_i | input | 1 | Enables the end-of-calibration interrupt |
| irq_clr_i | input | 1 | Write-one clear of the interrupt flag |
| run_req_i | input | 1 | Counter-start request |
| lock_i | input | 1 | Lock indication from the delay line |
| cal_req_o | output | 1 | Calibration request to the delay line |
| cal_busy_o | output | 1 | Calibrate bit readback (self-clearing) |
| ready_o | output | 1 | Sticky calibrated flag |
| irq_o | output | 1 | End-of-calibration interrupt flag |
| cnt_run_o | output | 1 | Gated counter-start |

## Verification
A wrong internal state shows at the ports quickly.

- A stuck calibrate bit or a wrong sequencer state shows on `cal_req_o` within two cycles of a start pulse or of a lock.
- A miscounting interval timer shows as a gap in `cal_req_o` that is off by one or more cycles. The gap is measured exactly, for every rate code, one full interval after the code is applied.
- A ready or interrupt flag that clears, or sets, at the wrong time is visible on `ready_o`, `irq_o` and `cnt_run_o` within one cycle.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_CAL = 1'b1} dl_state_e;

  // Rate code to log2 of the recalibration interval
  function automatic int unsigned interval_log2(int unsigned base, int unsigned code);
    return base + 2 * code;
  endfunction
endpackage

// File: rtl/dlcal_timer.sv
module dlcal_timer #(
  parameter int unsigned BASE_LOG2 = 14,
  parameter int unsigned CW        = BASE_LOG2 + 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       expire_o
);
  import dlcal_pkg::*;

  localparam int unsigned NCODES = 4;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term [NCODES];

  // Terminal count for each rate code
  for (genvar g = 0; g < NCODES; g++) begin : g_term
    localparam int unsigned LG = interval_log2(BASE_LOG2, g);
    assign term[g] = CW'((64'd1 << LG) - 64'd1);
  end

  assign expire_o = run_i && (cnt_q == term[rate_i]);

  always_ff @(posedge clk) begin
    if (rst || !run_i || expire_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dlcal_fsm.sv
module dlcal_fsm (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cal_start_i,
  input  logic                 expire_i,
  input  logic                 lock_i,
  output dlcal_pkg::dl_state_e state_o,
  output logic                 cal_bit_o,
  output logic                 done_o
);
  import dlcal_pkg::*;

  dl_state_e state_q;
  logic      cal_bit_q;
  logic      accept;

  assign accept = (state_q == ST_IDLE) && (cal_bit_q || expire_i);
  assign done_o = (state_q == ST_CAL) && lock_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cal_bit_q <= 1'b0;
    end else begin
      // A new write in the accept cycle wins over the self-clear
      if (cal_start_i)  cal_bit_q <= 1'b1;
      else if (accept)  cal_bit_q <= 1'b0;

      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_CAL;
        ST_CAL:  if (lock_i) state_q <= ST_IDLE;
        default:             state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign cal_bit_o = cal_bit_q;
endmodule

// File: rtl/dlcal_flags.sv
module dlcal_flags (
  input  logic clk,
  input  logic rst,
  input  logic done_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  input  logic run_req_i,
  output logic ready_o,
  output logic irq_o,
  output logic cnt_run_o
);
  logic ready_q, irq_q, run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (done_i) ready_q <= 1'b1;

      // Interrupt only on the first setting of ready; set beats clear
      if (done_i && !ready_q && irq_en_i) irq_q <= 1'b1;
      else if (irq_clr_i)                 irq_q <= 1'b0;

      run_q <= run_req_i && ready_q;
    end
  end

  assign ready_o   = ready_q;
  assign irq_o     = irq_q;
  assign cnt_run_o = run_q;
endmodule

// File: rtl/dlcal_seq.sv
module dlcal_seq #(
  parameter int unsigned BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cal_start_i,
  input  logic       per_en_i,
  input  logic [1:0] rate_i,
  input  logic       irq_en_i,
  input  logic       irq_clr_i,
  input  logic       run_req_i,
  input  logic       lock_i,
  output logic       cal_req_o,
  output logic       cal_busy_o,
  output logic       ready_o,
  output logic       irq_o,
  output logic       cnt_run_o
);
  import dlcal_pkg::*;

  localparam int unsigned TCW = interval_log2(BASE_LOG2, 3);

  dl_state_e state;
  logic      expire, done, tmr_run, ready;

  // Periodic timer runs only while idle, calibrated and enabled
  assign tmr_run = (state == ST_IDLE) && ready && per_en_i;

  dlcal_timer #(.BASE_LOG2(BASE_LOG2), .CW(TCW)) u_timer (
    .clk(clk), .rst(rst), .run_i(tmr_run), .rate_i(rate_i), .expire_o(expire)
  );

  dlcal_fsm u_fsm (
    .clk(clk), .rst(rst), .cal_start_i(cal_start_i), .expire_i(expire),
    .lock_i(lock_i), .state_o(state), .cal_bit_o(cal_busy_o), .done_o(done)
  );

  dlcal_flags u_flags (
    .clk(clk), .rst(rst), .done_i(done), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .run_req_i(run_req_i), .ready_o(ready),
    .irq_o(irq_o), .cnt_run_o(cnt_run_o)
  );

  assign ready_o   = ready;
  assign cal_req_o = (state == ST_CAL);
endmodule

// File: rtl/dlcal_seq_chk.sv
module dlcal_seq_chk (
  input logic clk,
  input logic rst,
  input logic cal_start_i,
  input logic per_en_i,
  input logic irq_en_i,
  input logic irq_clr_i,
  input logic run_req_i,
  input logic lock_i,
  input logic cal_req_o,
  input logic cal_busy_o,
  input logic ready_o,
  input logic irq_o,
  input logic cnt_run_o
);
  // R2: ready is sticky
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !$fell(ready_o));

  // R2: request ends only on a sampled lock
  assert_req_end_lock_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_req_o) |-> $past(lock_i));

  // R3, R7: interrupt rises only with the first ready, when enabled
  assert_irq_on_ready_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($rose(ready_o) && $past(irq_en_i)));

  // R4: counters run only once ready
  assert_run_gated_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_run_o |-> $past(ready_o) && $past(run_req_i));

  // R1, R5, R9: a calibration starts from the bit or from the periodic timer
  assert_req_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_req_o) |-> ($past(cal_busy_o) || ($past(per_en_i) && $past(ready_o))));

  // R8: clear without a competing set empties the flag
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i && !(cal_req_o && lock_i && !ready_o)) |=> !irq_o);

  // R10: lock outside calibration does not set ready
  assert_lock_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!cal_req_o && !ready_o) |=> !ready_o);
endmodule

bind dlcal_seq dlcal_seq_chk u_chk (
  .clk(clk), .rst(rst), .cal_start_i(cal_start_i), .per_en_i(per_en_i),
  .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i), .run_req_i(run_req_i),
  .lock_i(lock_i), .cal_req_o(cal_req_o), .cal_busy_o(cal_busy_o),
  .ready_o(ready_o), .irq_o(irq_o), .cnt_run_o(cnt_run_o)
);

// File: tb/dlcal_seq_bench.sv
module dlcal_seq_bench;
  localparam int BASE = 3;
  localparam int LOCK_DLY = 5;
  // rate code, expected gap in cycles: 2^(BASE + 2*code)
  localparam int VEC [4][2] = '{'{3, 512}, '{0, 8}, '{2, 128}, '{1, 32}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_start_i = 0, per_en_i = 0, irq_en_i = 0, irq_clr_i = 0, run_req_i = 0;
  logic [1:0] rate_i = 2'd0;
  logic lock_force = 0, model_en = 1, lock_q = 0;
  logic lock_i;
  logic cal_req_o, cal_busy_o, ready_o, irq_o, cnt_run_o;
  int   mcnt = 0;
  int   checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign lock_i = lock_q | lock_force;

  dlcal_seq #(.BASE_LOG2(BASE)) u_dlcal_seq (
    .clk(clk), .rst(rst), .cal_start_i(cal_start_i), .per_en_i(per_en_i),
    .rate_i(rate_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
    .run_req_i(run_req_i), .lock_i(lock_i), .cal_req_o(cal_req_o),
    .cal_busy_o(cal_busy_o), .ready_o(ready_o), .irq_o(irq_o),
    .cnt_run_o(cnt_run_o)
  );

  // Delay-line model: lock pulse LOCK_DLY cycles into a request
  always @(posedge clk) begin
    if (!cal_req_o || lock_q || !model_en) begin
      mcnt   <= 0;
      lock_q <= 1'b0;
    end else begin
      mcnt   <= mcnt + 1;
      lock_q <= (mcnt == LOCK_DLY - 1);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic pulse_start();
    cal_start_i = 1'b1;
    cyc(1);
    cal_start_i = 1'b0;
  endtask

  task automatic wait_level(input logic lvl);
    while (cal_req_o !== lvl) @(negedge clk);
  endtask

  task automatic main();
    int gap;
    bit rdy_ok, irq_ok, run_ok;

    // Reset state
    do_reset();
    chk({cal_req_o, cal_busy_o, ready_o, irq_o, cnt_run_o} == 5'b0, "R11",
        {cal_req_o, cal_busy_o, ready_o, irq_o, cnt_run_o}, 0);

    // per_en and a stray lock before any calibration
    per_en_i = 1; run_req_i = 1; lock_force = 1;
    cyc(40);
    chk(cal_req_o == 0, "R9", cal_req_o, 0);
    chk(ready_o == 0, "R10", ready_o, 0);
    chk(cnt_run_o == 0, "R4 blocked", cnt_run_o, 0);
    lock_force = 0; per_en_i = 0;

    // One-shot calibration, model held off to check request hold
    irq_en_i = 1; model_en = 0;
    pulse_start();
    chk(cal_busy_o == 1 && cal_req_o == 0, "R1 bit set", {cal_busy_o, cal_req_o}, 2);
    cyc(1);
    chk(cal_busy_o == 0 && cal_req_o == 1, "R1 accept", {cal_busy_o, cal_req_o}, 1);
    cyc(20);
    chk(cal_req_o == 1 && ready_o == 0, "R2 hold", {cal_req_o, ready_o}, 2);
    model_en = 1;
    wait_level(1'b0);
    chk(ready_o == 1, "R2 ready", ready_o, 1);
    chk(irq_o == 1, "R3 irq", irq_o, 1);
    cyc(1);
    chk(cnt_run_o == 1, "R4 run", cnt_run_o, 1);
    cyc(10);
    chk(irq_o == 1, "R8 hold", irq_o, 1);
    irq_clr_i = 1; cyc(1); irq_clr_i = 0;
    chk(irq_o == 0, "R8 clear", irq_o, 0);

    // Periodic recalibration, one vector per rate code
    per_en_i = 1;
    rdy_ok = 1; irq_ok = 1; run_ok = 1;
    for (int v = 0; v < 4; v++) begin
      rate_i = VEC[v][0][1:0];
      wait_level(1'b1);
      wait_level(1'b0);
      gap = 0;
      while (cal_req_o == 0) begin
        gap++;
        if (!ready_o) rdy_ok = 0;
        if (irq_o) irq_ok = 0;
        if (!cnt_run_o) run_ok = 0;
        @(negedge clk);
      end
      chk(gap == VEC[v][1], $sformatf("R5 R6 rate %0d", VEC[v][0]), gap, VEC[v][1]);
    end
    chk(rdy_ok, "R7 ready", rdy_ok, 1);
    chk(irq_ok, "R7 irq", irq_ok, 1);
    chk(run_ok, "R7 run", run_ok, 1);

    // Interrupt disabled at completion
    per_en_i = 0;
    do_reset();
    irq_en_i = 0;
    pulse_start();
    cyc(1);
    wait_level(1'b0);
    chk(ready_o == 1 && irq_o == 0, "R3 disabled", {ready_o, irq_o}, 2);

    // Lock pulse while idle and calibrated does not restart anything
    lock_force = 1; cyc(5); lock_force = 0;
    chk(cal_req_o == 0 && ready_o == 1, "R10 idle lock", {cal_req_o, ready_o}, 1);
  endtask

  initial begin
    fork
      main();
      begin
        cyc(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule